// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

This block collects event pulses from a set of peripheral sources, for example timer overflows, and turns them into one level-sensitive interrupt request toward a CPU core that has a single shared interrupt vector. Every source owns a sticky pending bit and an arm bit. A master enable sits above all of them, and the request is raised only when the master enable is on and some pending bit has its arm bit on.

The core answers a raised request by pulsing a vector-taken acknowledge, which switches the master enable off in the same clock step. It leaves the handler with a return strobe, which switches the master enable back on. Pending bits keep catching events while the master enable is off. A bit still pending and armed when the return strobe arrives therefore raises the request again straight away, so the event is deferred and never lost. Software sees all pending bits, arm bits and the master enable through a read port. It rewrites the arm bits and the master enable, and clears pending bits by mask. Nothing but such a clear removes a pending bit, and the block keeps no record of the order in which pending bits were set.

Top module: `single_vector_irq`

## Requirements
- R1: After reset, all pending bits, all arm bits, the master enable and the request output are 0.
- R2: A one-cycle pulse on bit k of `evt_i` sets pending bit k at the next clock edge, whatever the state of arm bit k and of the master enable.
- R3: `irq_o` is a registered level. After each clock edge it is 1 exactly when the master enable is 1 and at least one pending bit is 1 whose arm bit is also 1.
- R4: A pulse on `vec_taken_i` clears the master enable at the next clock edge, and `irq_o` is 0 after that edge.
- R5: A pulse on `vec_return_i` without `vec_taken_i` sets the master enable at the next edge. If an armed bit is pending at that point, `irq_o` is 1 right after that same edge.
- R6: A pending bit is cleared only by a clear write (`clr_we_i` high with bit k of `clr_wdata_i` at 1). Vector-taken, return, arm writes and master-enable writes leave pending bits unchanged.
- R7: When an event on bit k and a clear of bit k fall in the same cycle, pending bit k ends up 1.
- R8: The master enable is updated with this priority, highest first: `vec_taken_i` clears it, `vec_return_i` sets it, and a software write (`master_we_i`) loads `master_wdata_i`.
- R9: `pend_o`, `arm_o` and `master_o` show the current pending bits, arm bits and master enable. Bit k of each vector belongs to source k.
- R10: A write with `arm_we_i` high replaces all arm bits with `arm_wdata_i`. A pending bit whose arm bit is 0 never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N_SRC | One-cycle event pulses, one per source |
| vec_taken_i | input | 1 | Core has taken the vector |
| vec_return_i | input | 1 | Core returns from the handler |
| arm_we_i | input | 1 | Write strobe for the arm bits |
| arm_wdata_i | input | N_SRC | New arm bits |
| master_we_i | input | 1 | Write strobe for the master enable |
| master_wdata_i | input | 1 | New master enable value |
| clr_we_i | input | 1 | Write strobe for pending-bit clears |
| clr_wdata_i | input | N_SRC | Mask of pending bits to clear |
| pend_o | output | N_SRC | Pending bits |
| arm_o | output | N_SRC | Arm bits |
| master_o | output | 1 | Master enable |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
Two pairs of functions can fall in the same cycle here. An event can meet a software clear of the same pending bit, and a vector-taken acknowledge can meet a return strobe, optionally together with a master-enable write. The bench drives each pair in one step. For each step the scoreboard computes from the requirements which action wins: the event keeps the bit, the acknowledge clears the master enable, and the return beats a software write. It then compares pending bits, master enable and request after that edge.

// File: rtl/single_vector_irq.sv
module single_vector_irq #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             vec_taken_i,
  input  logic             vec_return_i,
  input  logic             arm_we_i,
  input  logic [N_SRC-1:0] arm_wdata_i,
  input  logic             master_we_i,
  input  logic             master_wdata_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_wdata_i,
  output logic [N_SRC-1:0] pend_o,
  output logic [N_SRC-1:0] arm_o,
  output logic             master_o,
  output logic             irq_o
);

  logic [N_SRC-1:0] pend_q, arm_q, pend_d, arm_d;
  logic             master_q, master_d, irq_q, irq_d;

  // events win over a clear of the same bit
  assign pend_d = (pend_q & ~(clr_we_i ? clr_wdata_i : '0)) | evt_i;
  assign arm_d  = arm_we_i ? arm_wdata_i : arm_q;

  always_comb begin
    master_d = master_q;
    if (vec_taken_i)       master_d = 1'b0;
    else if (vec_return_i) master_d = 1'b1;
    else if (master_we_i)  master_d = master_wdata_i;
  end

  assign irq_d = master_d & (|(pend_d & arm_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      arm_q    <= '0;
      master_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      arm_q    <= arm_d;
      master_q <= master_d;
      irq_q    <= irq_d;
    end
  end

  assign pend_o   = pend_q;
  assign arm_o    = arm_q;
  assign master_o = master_q;
  assign irq_o    = irq_q;

  assert_event_sets_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  assert_irq_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (master_q && ((pend_q & arm_q) != '0)));

  assert_take_drops_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_taken_i |=> (!master_q && !irq_q));

  assert_return_sets_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_return_i && !vec_taken_i) |=> master_q);

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  assert_event_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && ((clr_wdata_i & evt_i) != '0)) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  assert_unarmed_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & arm_q) == '0) |-> !irq_q);

endmodule

// File: tb/test_single_vector_irq.sv
`timescale 1ns/1ps
module test_single_vector_irq;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] evt = '0, arm_d = '0, clr_d = '0;
  logic take = 1'b0, ret = 1'b0, arm_we = 1'b0, mst_we = 1'b0, mst_d = 1'b0, clr_we = 1'b0;
  logic [N-1:0] pend, arm;
  logic mst, irq;

  always #2.5 clk = ~clk;

  single_vector_irq #(.N_SRC(N)) i_single_vector_irq (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .vec_taken_i(take), .vec_return_i(ret),
    .arm_we_i(arm_we), .arm_wdata_i(arm_d), .master_we_i(mst_we), .master_wdata_i(mst_d),
    .clr_we_i(clr_we), .clr_wdata_i(clr_d), .pend_o(pend), .arm_o(arm),
    .master_o(mst), .irq_o(irq));

  typedef struct {
    logic [N-1:0] pend;
    logic [N-1:0] arm;
    logic         mst;
    logic         irq;
    string        tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit done = 0;
  logic [N-1:0] m_pend = '0, m_arm = '0;
  logic m_mst = 1'b0;

  function automatic exp_t snap(input string tag);
    exp_t e;
    e.pend = m_pend; e.arm = m_arm; e.mst = m_mst;
    e.irq  = m_mst & (|(m_pend & m_arm));
    e.tag  = tag;
    return e;
  endfunction

  task automatic step(input logic [N-1:0] ev, input logic tk, input logic rt,
                      input logic awe, input logic [N-1:0] ad,
                      input logic mwe, input logic md,
                      input logic cwe, input logic [N-1:0] cd, input string tag);
    @(negedge clk);
    evt = ev; take = tk; ret = rt; arm_we = awe; arm_d = ad;
    mst_we = mwe; mst_d = md; clr_we = cwe; clr_d = cd;
    m_pend = (m_pend & ~(cwe ? cd : '0)) | ev;
    if (awe) m_arm = ad;
    if (tk) m_mst = 1'b0;
    else if (rt) m_mst = 1'b1;
    else if (mwe) m_mst = md;
    @(posedge clk);
    #1;
    q.push_back(snap(tag));
    evt = '0; take = 0; ret = 0; arm_we = 0; mst_we = 0; clr_we = 0;
  endtask

  // monitor: compares design outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (pend !== e.pend || arm !== e.arm || mst !== e.mst || irq !== e.irq) begin
          bad++;
          $display("FAIL %s: got pend=%b arm=%b mst=%b irq=%b, expected pend=%b arm=%b mst=%b irq=%b",
                   e.tag, pend, arm, mst, irq, e.pend, e.arm, e.mst, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    q.push_back(snap("R1 reset state"));
    @(negedge clk);
    rst_n = 1'b1;
    step(4'b0001, 0,0, 0,'0, 0,0, 0,'0, "R2 event while unarmed and master off");
    step('0, 0,0, 1,4'b0010, 0,0, 0,'0, "R10 arm write other source");
    step('0, 0,0, 0,'0, 1,1, 0,'0, "R10 master on, pending source unarmed");
    step('0, 0,0, 1,4'b0001, 0,0, 0,'0, "R3 arming pending source raises irq");
    step('0, 1,0, 0,'0, 0,0, 0,'0, "R4 vector taken drops master and irq");
    step(4'b0010, 0,0, 0,'0, 0,0, 0,'0, "R2 event while master off");
    step('0, 0,0, 1,4'b0011, 0,0, 0,'0, "R6 arm write keeps pending");
    step('0, 0,0, 0,'0, 0,0, 1,4'b0001, "R6 clear by mask bit 0");
    step('0, 0,1, 0,'0, 0,0, 0,'0, "R5 return re-raises irq for pending bit 1");
    step('0, 1,1, 0,'0, 0,0, 0,'0, "R8 taken beats return");
    step(4'b0010, 0,0, 0,'0, 0,0, 1,4'b0010, "R7 event beats clear same bit");
    step('0, 0,1, 0,'0, 1,0, 0,'0, "R8 return beats software write of 0");
    step('0, 0,0, 0,'0, 0,0, 1,4'b1111, "R6 clear all drops irq");
    step(4'b1100, 0,0, 1,4'b1000, 0,0, 0,'0, "R9 two events same cycle read back");
    step('0, 0,0, 0,'0, 1,0, 0,'0, "R8 software write clears master");
    step('0, 0,0, 0,'0, 0,0, 0,'0, "R6 idle keeps state");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule